// File: doc/BRIEF.md
# Pulse-and-Verify OTP Programming Sequencer

This block sits on the programmer side of a one-time-programmable word memory. It walks an image of words into the part using fixed-width program pulses, and it sets the memory address, the data bus, the active-low chip and output enables, and the requests for the raised supply and the program voltage. The image word for the current address comes in combinationally from an outside source, and read-back data comes in from the memory.

A run has three stages. In the first stage each word gets a single program pulse with no check. In the second stage each word is read back and compared. A word that does not match gets further pulses, with a read-back after each one, up to a bounded count. In the third stage the supply requests are dropped and the whole image is read back at normal supply. Every wait is counted in microseconds from a prescaled clock tick, except the read sample delay and the bus float gap, which are counted in clock cycles. Status is reported through a level start, a held done, pass and fail flags, and the failing address.

Top module: `otp_prog_seq`

## Requirements
- R1: While reset is low and on leaving it, ceN and oeN are 1 (deasserted), memDoutEn, vccHiReq, vppReq, busy and done are 0.
- R2: A high start while idle begins a run and raises busy. While busy, start is ignored. done stays 1 for as long as start stays high, and no new run begins. One clock after start goes low, done and busy are 0.
- R3: vccHiReq rises before vppReq and falls after it, so vppReq is never 1 while vccHiReq is 0.
- R4: Each program pulse (ceN low with oeN high) begins at least SETUP_US µs after the last change of address, data or drive enable, after oeN rose, and after vppReq rose. Address, data and drive stay unchanged for at least HOLD_US µs after the pulse ends.
- R5: Each program pulse lasts between 47.5 and 52.5 µs (PULSE_US=50 nominal).
- R6: In the first stage, address k (k = 0, 1, ...) gets pulse number k, exactly one pulse per word, and oeN stays 1 until every word has had its pulse.
- R7: In the second stage a word that mismatches gets up to MAX_RETRY (10) extra pulses, with a read-back after each. A word that needs n ≤ 11 pulses in total gets exactly n.
- R8: If a word still mismatches after MAX_RETRY extra pulses, the run stops with failed=1 and failAddr set to that word's address. No later word gets an extra pulse, and no final read-back takes place.
- R9: The final read-back takes place with vccHiReq and vppReq both 0 and reads the words in ascending order. The first mismatch ends the run with failed=1 and failAddr at that word. If every word matches, passOk=1.
- R10: A read-back holds ceN and oeN at 0 for at least OE_WAIT_CYC cycles before it samples readData. memDoutEn is never 1 while oeN is 0, and memDoutEn rises no sooner than FLOAT_CYC cycles after oeN rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Level request to run a programming pass |
| imgData | input | DATA_W | Image word for the current memAddr |
| readData | input | DATA_W | Data read back from the memory |
| memAddr | output | ADDR_W | Memory word address |
| memDout | output | DATA_W | Data presented to the memory |
| memDoutEn | output | 1 | Programmer drives memDout when 1 |
| ceN | output | 1 | Active-low chip enable, used for the program pulse |
| oeN | output | 1 | Active-low output enable, used for read-back |
| vccHiReq | output | 1 | Request for the raised supply |
| vppReq | output | 1 | Request for the program voltage |
| busy | output | 1 | A run is in progress |
| done | output | 1 | Run finished, held while start is high |
| passOk | output | 1 | With done: every word verified at normal supply |
| failed | output | 1 | With done: a word failed |
| failAddr | output | ADDR_W | Address of the failing word |

## Verification
The bench builds weak words that need a set number of pulses. One word needs exactly eleven pulses, which must pass. One word needs twelve, which must fail, and this case is tried at a middle address and at the last address. A design whose retry count is off by one would fail the eleven-pulse word or accept the twelve-pulse one, and a design that kept going after a failure would show extra pulses at later addresses. A word that reads back correctly only at raised supply exposes a design that skips the final read-back or runs it with the supply still raised. Monitors time every pulse, setup, hold, read sample and float gap, so a timer off by a tick or an enable that overlaps the drive is seen at the pins.

// File: rtl/otp_prog_pkg.sv
package otp_prog_pkg;

  localparam int TIME_W = 16;

  typedef enum logic [3:0] {
    S_IDLE, S_VPP_UP, S_VSETUP, S_DSETUP, S_PULSE, S_HOLD,
    S_VERIFY, S_FLOAT, S_VPP_DN, S_VCC_DN, S_SETTLE, S_DONE
  } progState_t;

  typedef enum logic [1:0] {PH_BLIND, PH_VERIFY, PH_FINAL} progPhase_t;

  typedef struct packed {
    logic              addrClr;
    logic              addrInc;
    logic              retryClr;
    logic              retryInc;
    logic              usLoad;
    logic [TIME_W-1:0] usVal;
    logic              cycLoad;
    logic [TIME_W-1:0] cycVal;
    logic              vccSet;
    logic              vccClr;
    logic              vppSet;
    logic              vppClr;
    logic              sample;
    logic              failSet;
    logic              failClr;
  } progStrobe_t;

endpackage

// File: rtl/otp_prog_dp.sv
module otp_prog_dp
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W     = 18,
  parameter int DATA_W     = 16,
  parameter int WORDS      = 2 ** ADDR_W,
  parameter int CLK_PER_US = 100,
  parameter int MAX_RETRY  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  progStrobe_t       strb,
  input  logic [DATA_W-1:0] imgData,
  input  logic [DATA_W-1:0] readData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              vccHiReq,
  output logic              vppReq,
  output logic              usDone,
  output logic              cycDone,
  output logic              isLast,
  output logic              retryMax,
  output logic              wordMatch,
  output logic              failFlag,
  output logic [ADDR_W-1:0] failAddr
);

  localparam int PRE_W = $clog2(CLK_PER_US + 1);
  localparam int RET_W = $clog2(MAX_RETRY + 1);
  localparam logic [ADDR_W-1:0] LAST_ADDR = ADDR_W'(WORDS - 1);

  logic [ADDR_W-1:0] addrQ;
  logic [RET_W-1:0]  retryQ;
  logic [TIME_W-1:0] usLeft;
  logic [TIME_W-1:0] cycLeft;
  logic              usTick;
  logic              vccQ, vppQ, matchQ, failQ;
  logic [ADDR_W-1:0] failAddrQ;

  // address walker
  always_ff @(posedge clk) begin
    if (!rstN)             addrQ <= '0;
    else if (strb.addrClr) addrQ <= '0;
    else if (strb.addrInc) addrQ <= addrQ + 1'b1;
  end

  // extra-pulse counter for the word under verify
  always_ff @(posedge clk) begin
    if (!rstN)              retryQ <= '0;
    else if (strb.retryClr) retryQ <= '0;
    else if (strb.retryInc) retryQ <= retryQ + 1'b1;
  end

  // microsecond prescaler: restarts on every load so waits are exact
  generate
    if (CLK_PER_US > 1) begin : gPre
      logic [PRE_W-1:0] preQ;
      always_ff @(posedge clk) begin
        if (!rstN)                     preQ <= '0;
        else if (strb.usLoad || usTick) preQ <= '0;
        else                           preQ <= preQ + 1'b1;
      end
      assign usTick = (preQ == PRE_W'(CLK_PER_US - 1));
    end else begin : gNoPre
      assign usTick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN)                       usLeft <= '0;
    else if (strb.usLoad)            usLeft <= strb.usVal;
    else if (usTick && usLeft != '0) usLeft <= usLeft - 1'b1;
  end

  // cycle-granular timer for read sample and bus float
  always_ff @(posedge clk) begin
    if (!rstN)              cycLeft <= '0;
    else if (strb.cycLoad)  cycLeft <= strb.cycVal;
    else if (cycLeft != '0) cycLeft <= cycLeft - 1'b1;
  end

  // supply request flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vccQ <= 1'b0;
      vppQ <= 1'b0;
    end else begin
      if (strb.vccSet)      vccQ <= 1'b1;
      else if (strb.vccClr) vccQ <= 1'b0;
      if (strb.vppSet)      vppQ <= 1'b1;
      else if (strb.vppClr) vppQ <= 1'b0;
    end
  end

  // compare and result capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      matchQ    <= 1'b0;
      failQ     <= 1'b0;
      failAddrQ <= '0;
    end else begin
      if (strb.sample) matchQ <= (readData == imgData);
      if (strb.failClr) begin
        failQ     <= 1'b0;
        failAddrQ <= '0;
      end else if (strb.failSet) begin
        failQ     <= 1'b1;
        failAddrQ <= addrQ;
      end
    end
  end

  assign memAddr   = addrQ;
  assign memDout   = imgData;
  assign vccHiReq  = vccQ;
  assign vppReq    = vppQ;
  assign usDone    = (usLeft == '0);
  assign cycDone   = (cycLeft == '0);
  assign isLast    = (addrQ == LAST_ADDR);
  assign retryMax  = (retryQ == RET_W'(MAX_RETRY));
  assign wordMatch = matchQ;
  assign failFlag  = failQ;
  assign failAddr  = failAddrQ;

  // R3: program voltage only on top of the raised supply
  a_r3_vpp_needs_vcc: assert property (@(posedge clk) disable iff (!rstN)
    vppQ |-> vccQ);

  // R7: extra pulses never exceed the bound
  a_r7_retry_bound: assert property (@(posedge clk) disable iff (!rstN)
    retryQ <= RET_W'(MAX_RETRY));

  // R8: a recorded failure stays until the next run clears it
  a_r8_fail_hold: assert property (@(posedge clk) disable iff (!rstN)
    (failQ && !strb.failClr) |=> (failQ && $stable(failAddrQ)));

endmodule

// File: rtl/otp_prog_ctrl.sv
module otp_prog_ctrl
  import otp_prog_pkg::*;
#(
  parameter int CLK_PER_US  = 100,
  parameter int PULSE_US    = 50,
  parameter int SETUP_US    = 2,
  parameter int HOLD_US     = 2,
  parameter int VSET_US     = 2,
  parameter int OE_WAIT_CYC = 15,
  parameter int FLOAT_CYC   = 13
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        usDone,
  input  logic        cycDone,
  input  logic        isLast,
  input  logic        retryMax,
  input  logic        wordMatch,
  input  logic        failFlag,
  output progStrobe_t strb,
  output logic        ceN,
  output logic        oeN,
  output logic        memDoutEn,
  output logic        busy,
  output logic        done
);

  localparam logic [TIME_W-1:0] T_PULSE = TIME_W'(PULSE_US);
  localparam logic [TIME_W-1:0] T_SETUP = TIME_W'(SETUP_US);
  localparam logic [TIME_W-1:0] T_HOLD  = TIME_W'(HOLD_US);
  localparam logic [TIME_W-1:0] T_VSET  = TIME_W'(VSET_US);
  localparam logic [TIME_W-1:0] T_OE    = TIME_W'(OE_WAIT_CYC);
  localparam logic [TIME_W-1:0] T_FLOAT = TIME_W'(FLOAT_CYC);
  localparam int PULSE_MIN_CYC = (475 * CLK_PER_US + 9) / 10;
  localparam int PULSE_MAX_CYC = (525 * CLK_PER_US) / 10;

  progState_t state, nxt;
  progPhase_t phase, phNxt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_BLIND;
    end else begin
      state <= nxt;
      phase <= phNxt;
    end
  end

  always_comb begin
    strb  = '0;
    nxt   = state;
    phNxt = phase;
    case (state)
      S_IDLE: if (start) begin
        strb.failClr  = 1'b1;
        strb.addrClr  = 1'b1;
        strb.retryClr = 1'b1;
        strb.vccSet   = 1'b1;
        nxt           = S_VPP_UP;
      end
      S_VPP_UP: begin
        strb.vppSet = 1'b1;
        strb.usLoad = 1'b1;
        strb.usVal  = T_VSET;
        nxt         = S_VSETUP;
      end
      S_VSETUP: if (usDone) begin
        strb.usLoad = 1'b1;
        strb.usVal  = T_SETUP;
        phNxt       = PH_BLIND;
        nxt         = S_DSETUP;
      end
      S_DSETUP: if (usDone) begin
        strb.usLoad = 1'b1;
        strb.usVal  = T_PULSE;
        nxt         = S_PULSE;
      end
      S_PULSE: if (usDone) begin
        strb.usLoad = 1'b1;
        strb.usVal  = T_HOLD;
        nxt         = S_HOLD;
      end
      S_HOLD: if (usDone) begin
        if (phase == PH_BLIND && !isLast) begin
          strb.addrInc = 1'b1;
          strb.usLoad  = 1'b1;
          strb.usVal   = T_SETUP;
          nxt          = S_DSETUP;
        end else begin
          if (phase == PH_BLIND) begin
            strb.addrClr  = 1'b1;
            strb.retryClr = 1'b1;
            phNxt         = PH_VERIFY;
          end
          strb.cycLoad = 1'b1;
          strb.cycVal  = T_OE;
          nxt          = S_VERIFY;
        end
      end
      S_VERIFY: if (cycDone) begin
        strb.sample  = 1'b1;
        strb.cycLoad = 1'b1;
        strb.cycVal  = T_FLOAT;
        nxt          = S_FLOAT;
      end
      S_FLOAT: if (cycDone) begin
        if (wordMatch) begin
          if (isLast) begin
            nxt = (phase == PH_FINAL) ? S_DONE : S_VPP_DN;
          end else begin
            strb.addrInc  = 1'b1;
            strb.retryClr = 1'b1;
            strb.cycLoad  = 1'b1;
            strb.cycVal   = T_OE;
            nxt           = S_VERIFY;
          end
        end else if (phase == PH_FINAL || retryMax) begin
          strb.failSet = 1'b1;
          nxt          = (phase == PH_FINAL) ? S_DONE : S_VPP_DN;
        end else begin
          strb.retryInc = 1'b1;
          strb.usLoad   = 1'b1;
          strb.usVal    = T_SETUP;
          nxt           = S_DSETUP;
        end
      end
      S_VPP_DN: begin
        strb.vppClr = 1'b1;
        nxt         = S_VCC_DN;
      end
      S_VCC_DN: begin
        strb.vccClr = 1'b1;
        strb.usLoad = 1'b1;
        strb.usVal  = T_VSET;
        nxt         = S_SETTLE;
      end
      S_SETTLE: if (usDone) begin
        if (failFlag) begin
          nxt = S_DONE;
        end else begin
          strb.addrClr = 1'b1;
          strb.cycLoad = 1'b1;
          strb.cycVal  = T_OE;
          phNxt        = PH_FINAL;
          nxt          = S_VERIFY;
        end
      end
      S_DONE: if (!start) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign ceN       = !(state == S_PULSE || state == S_VERIFY);
  assign oeN       = (state != S_VERIFY);
  assign memDoutEn = (state == S_DSETUP || state == S_PULSE || state == S_HOLD);
  assign busy      = (state != S_IDLE && state != S_DONE);
  assign done      = (state == S_DONE);

  // checker-only pulse length counter
  int pulseLen;
  always_ff @(posedge clk) begin
    if (!rstN)                 pulseLen <= 0;
    else if (state == S_PULSE) pulseLen <= pulseLen + 1;
    else                       pulseLen <= 0;
  end

  // R5: pulse length held inside its tolerance window
  a_r5_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PULSE && nxt != S_PULSE) |->
      (pulseLen + 1 >= PULSE_MIN_CYC && pulseLen + 1 <= PULSE_MAX_CYC));

  // R10: never drive the bus while the memory may be driving it
  a_r10_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    memDoutEn |-> oeN);

  // R2: done held while start stays high
  a_r2_done_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DONE && start) |=> (state == S_DONE));

  // R6: no read-back during the blind stage
  a_r6_blind_no_read: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_BLIND) |-> oeN);

endmodule

// File: rtl/otp_prog_seq.sv
module otp_prog_seq
  import otp_prog_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int WORDS       = 2 ** ADDR_W,
  parameter int CLK_PER_US  = 100,
  parameter int PULSE_US    = 50,
  parameter int SETUP_US    = 2,
  parameter int HOLD_US     = 2,
  parameter int VSET_US     = 2,
  parameter int MAX_RETRY   = 10,
  parameter int OE_WAIT_CYC = 15,
  parameter int FLOAT_CYC   = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [DATA_W-1:0] imgData,
  input  logic [DATA_W-1:0] readData,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDout,
  output logic              memDoutEn,
  output logic              ceN,
  output logic              oeN,
  output logic              vccHiReq,
  output logic              vppReq,
  output logic              busy,
  output logic              done,
  output logic              passOk,
  output logic              failed,
  output logic [ADDR_W-1:0] failAddr
);

  progStrobe_t strb;
  logic usDone, cycDone, isLast, retryMax, wordMatch, failFlag;

  otp_prog_ctrl #(
    .CLK_PER_US (CLK_PER_US), .PULSE_US (PULSE_US), .SETUP_US (SETUP_US),
    .HOLD_US (HOLD_US), .VSET_US (VSET_US),
    .OE_WAIT_CYC (OE_WAIT_CYC), .FLOAT_CYC (FLOAT_CYC)
  ) uCtrl (
    .clk, .rstN, .start, .usDone, .cycDone, .isLast, .retryMax,
    .wordMatch, .failFlag, .strb, .ceN, .oeN, .memDoutEn, .busy, .done
  );

  otp_prog_dp #(
    .ADDR_W (ADDR_W), .DATA_W (DATA_W), .WORDS (WORDS),
    .CLK_PER_US (CLK_PER_US), .MAX_RETRY (MAX_RETRY)
  ) uDp (
    .clk, .rstN, .strb, .imgData, .readData, .memAddr, .memDout,
    .vccHiReq, .vppReq, .usDone, .cycDone, .isLast, .retryMax,
    .wordMatch, .failFlag, .failAddr
  );

  assign passOk = done && !failFlag;
  assign failed = done && failFlag;

endmodule

// File: tb/sim_otp_prog_seq.sv
module sim_otp_prog_seq;

  localparam int AW   = 3;
  localparam int N    = 8;
  localparam int CPU  = 4;
  localparam int OEW  = 15;
  localparam int FLT  = 13;
  localparam int MAXR = 10;
  localparam int SETC = 2 * CPU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [15:0] imgData, readData, memDout;
  logic [AW-1:0] memAddr, failAddr;
  logic memDoutEn, ceN, oeN, vccHiReq, vppReq, busy, done, passOk, failed;

  always #5 clk = ~clk;

  otp_prog_seq #(.ADDR_W(AW), .DATA_W(16), .WORDS(N), .CLK_PER_US(CPU),
                 .MAX_RETRY(MAXR), .OE_WAIT_CYC(OEW), .FLOAT_CYC(FLT)) u0 (
    .clk, .rstN, .start, .imgData, .readData, .memAddr, .memDout, .memDoutEn,
    .ceN, .oeN, .vccHiReq, .vppReq, .busy, .done, .passOk, .failed, .failAddr);

  // scenario table: weak word A, weak word B, marginal word
  localparam int NV = 7;
  localparam int V_WA[NV]   = '{0, 3, 5, 2, 1, 0, 7};
  localparam int V_NA[NV]   = '{1, 5, 11, 12, 2, 2, 12};
  localparam int V_WB[NV]   = '{1, 7, 6, 6, 2, 7, 0};
  localparam int V_NB[NV]   = '{1, 1, 1, 3, 1, 3, 1};
  localparam int V_MEN[NV]  = '{0, 0, 0, 0, 1, 0, 0};
  localparam int V_MA[NV]   = '{0, 0, 0, 0, 6, 0, 0};

  int curWA, curNA, curWB, curNB, curMen, curMA;
  int checks = 0, fails = 0;

  function automatic logic [15:0] imgOf(int a);
    return (a == 4) ? 16'hFFFF : (16'h3C5A ^ 16'(a * 16'h0123));
  endfunction

  function automatic int needOf(int a);
    if (a == curWA) return curNA;
    if (a == curWB) return curNB;
    return 1;
  endfunction

  assign imgData = imgOf(int'(memAddr));

  // behavioural memory: a word programs once it has seen needOf() pulses
  logic [15:0] stored [N];
  int pulseCnt [N];
  logic memClr = 1'b0;
  logic mpCe = 1'b1;

  always @(negedge clk) begin
    if (memClr) begin
      for (int i = 0; i < N; i++) begin
        stored[i]   = 16'hFFFF;
        pulseCnt[i] = 0;
      end
    end else if (rstN && mpCe && !ceN && oeN && vppReq && vccHiReq) begin
      pulseCnt[memAddr] = pulseCnt[memAddr] + 1;
      if (pulseCnt[memAddr] >= needOf(int'(memAddr)))
        stored[memAddr] = stored[memAddr] & memDout;
    end
    mpCe = ceN;
  end

  always_comb begin
    if (!ceN && !oeN) begin
      if (!vccHiReq && curMen != 0 && int'(memAddr) == curMA)
        readData = stored[memAddr] ^ 16'h0100;
      else
        readData = stored[memAddr];
    end else begin
      readData = 16'hDEAD;
    end
  end

  // pin-level timing monitors
  int cyc = 0;
  logic pCe = 1'b1, pOe = 1'b1, pEn = 1'b0, pVpp = 1'b0, pBusy = 1'b0;
  logic [AW-1:0] pAddr = '0;
  logic [15:0] pDout = '0;
  int lastAddrChg = -1000, lastDataChg = -1000, lastOeRise = -1000, vppRise = -1000;
  int pulseStart = 0, pulseEnd = 0, oeFall = 0;
  bit holdPend = 0, inPulse = 0, seenOe = 0;
  int runPulses = 0, finalReads = 0;
  int vSetup = 0, vWidth = 0, vHold = 0, vSupply = 0, vContend = 0;
  int vBlind = 0, vVerify = 0, vFloat = 0, vFinal = 0;

  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rstN) begin
      holdPend = 0; inPulse = 0;
    end else begin
      if (busy && !pBusy) begin runPulses = 0; seenOe = 0; finalReads = 0; end
      if (memAddr != pAddr) lastAddrChg = cyc;
      if (memDout != pDout || memDoutEn != pEn) lastDataChg = cyc;
      if (holdPend && (memAddr != pAddr || memDout != pDout || memDoutEn != pEn)) begin
        if (cyc - pulseEnd < SETC) vHold++;
        holdPend = 0;
      end
      if (vppReq && !vccHiReq) vSupply++;
      if (memDoutEn && !oeN) vContend++;
      if (pCe && !ceN && oeN) begin
        if (!vppReq || !memDoutEn || cyc - lastAddrChg < SETC || cyc - lastDataChg < SETC ||
            cyc - lastOeRise < SETC || cyc - vppRise < SETC) vSetup++;
        if (!seenOe && int'(memAddr) != runPulses) vBlind++;
        runPulses++; inPulse = 1; pulseStart = cyc;
      end
      if (!pCe && ceN && inPulse) begin
        if ((cyc - pulseStart) * 10 < 475 * CPU || (cyc - pulseStart) * 10 > 525 * CPU) vWidth++;
        inPulse = 0; pulseEnd = cyc; holdPend = 1;
      end
      if (pOe && !oeN) begin
        if (ceN) vVerify++;
        if (!seenOe && runPulses != N) vBlind++;
        seenOe = 1; oeFall = cyc;
        if (!vppReq) begin
          finalReads++;
          if (vccHiReq) vFinal++;
        end
      end
      if (!pOe && oeN) begin
        if (cyc - oeFall < OEW) vVerify++;
        lastOeRise = cyc;
      end
      if (memDoutEn && !pEn && cyc - lastOeRise < FLT) vFloat++;
      if (vppReq && !pVpp) vppRise = cyc;
    end
    pCe = ceN; pOe = oeN; pEn = memDoutEn; pVpp = vppReq; pBusy = busy;
    pAddr = memAddr; pDout = memDout;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setScen(input int wa, na, wb, nb, men, ma);
    curWA = wa; curNA = na; curWB = wb; curNB = nb; curMen = men; curMA = ma;
    @(negedge clk); memClr = 1'b1;
    @(negedge clk); memClr = 1'b0;
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 30000) begin @(negedge clk); n++; end
    chk(done == 1'b1, req, "run reaches done", int'(done), 1);
  endtask

  task automatic checkMonitors();
    chk(vSupply == 0, "R3", "supply order violations", vSupply, 0);
    chk(vSetup == 0 && vHold == 0, "R4", "setup/hold violations", vSetup + vHold, 0);
    chk(vWidth == 0, "R5", "pulse width violations", vWidth, 0);
    chk(vBlind == 0, "R6", "blind stage order violations", vBlind, 0);
    chk(vFinal == 0, "R9", "final read at raised supply", vFinal, 0);
    chk(vVerify == 0 && vContend == 0 && vFloat == 0, "R10", "read/float violations",
        vVerify + vContend + vFloat, 0);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    curWA = 0; curNA = 1; curWB = 0; curNB = 1; curMen = 0; curMA = 0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ceN && oeN && !memDoutEn && !vccHiReq && !vppReq && !busy && !done, "R1",
        "reset outputs idle", {ceN, oeN, memDoutEn, vccHiReq, vppReq, busy, done}, 7'b1100000);
    rstN = 1'b1;
    @(negedge clk);
    chk(ceN && oeN && !busy && !done, "R1", "idle after reset release",
        {ceN, oeN, busy, done}, 4'b1100);

    for (int v = 0; v < NV; v++) begin
      int expTot, expFA, expFinal;
      bit expFail, p2Fail;
      setScen(V_WA[v], V_NA[v], V_WB[v], V_NB[v], V_MEN[v], V_MA[v]);
      expTot = N; expFail = 0; p2Fail = 0; expFA = 0;
      for (int a = 0; a < N; a++) begin
        if (needOf(a) > MAXR + 1) begin
          expTot += MAXR; p2Fail = 1; expFail = 1; expFA = a;
          break;
        end
        expTot += needOf(a) - 1;
      end
      if (!expFail && curMen != 0) begin expFail = 1; expFA = curMA; end
      expFinal = p2Fail ? 0 : (curMen != 0 ? curMA + 1 : N);
      start = 1'b1;
      @(negedge clk); @(negedge clk);
      chk(busy == 1'b1, "R2", "busy after start", int'(busy), 1);
      waitDone("R2");
      chk(failed == expFail && passOk == !expFail, "R9", "pass/fail result",
          {passOk, failed}, {!expFail, expFail});
      if (expFail) chk(int'(failAddr) == expFA, p2Fail ? "R8" : "R9", "failAddr",
                       int'(failAddr), expFA);
      chk(runPulses == expTot, p2Fail ? "R8" : "R7", "total pulses", runPulses, expTot);
      chk(pulseCnt[curWA] == ((p2Fail && curWA > expFA) ? 1 : (needOf(curWA) > MAXR + 1 ? MAXR + 1 : needOf(curWA))),
          "R7", "pulses at weak word", pulseCnt[curWA], needOf(curWA));
      chk(finalReads == expFinal, "R9", "final read-back count", finalReads, expFinal);
      checkMonitors();
      start = 1'b0;
      @(negedge clk);
      chk(!done && !busy, "R2", "done clears after start low", {done, busy}, 0);
    end

    // R2: start dropped and re-raised while busy is ignored; done held, no restart
    setScen(0, 1, 1, 1, 0, 0);
    start = 1'b1;
    repeat (100) @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    chk(busy == 1'b1, "R2", "run continues with start low", int'(busy), 1);
    start = 1'b1;
    waitDone("R2");
    chk(passOk == 1'b1 && runPulses == N, "R2", "single run, pulses", runPulses, N);
    repeat (300) @(negedge clk);
    chk(done == 1'b1 && !busy && runPulses == N, "R2", "held done, no restart", runPulses, N);
    start = 1'b0;
    @(negedge clk);
    chk(!done && !busy, "R2", "idle after start low", {done, busy}, 0);

    // R1: reset in the middle of a run returns outputs to idle
    setScen(3, 5, 0, 1, 0, 0);
    start = 1'b1;
    repeat (400) @(negedge clk);
    rstN = 1'b0;
    start = 1'b0;
    @(negedge clk); @(negedge clk);
    chk(ceN && oeN && !memDoutEn && !vccHiReq && !vppReq && !busy && !done, "R1",
        "mid-run reset outputs", {ceN, oeN, memDoutEn, vccHiReq, vppReq, busy, done}, 7'b1100000);
    rstN = 1'b1;
    @(negedge clk);

    // recovery run after reset
    setScen(6, 4, 0, 1, 0, 0);
    start = 1'b1;
    waitDone("R7");
    chk(passOk == 1'b1 && pulseCnt[6] == 4, "R7", "recovery run pulses at word 6", pulseCnt[6], 4);
    checkMonitors();
    start = 1'b0;
    @(negedge clk);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule